// File: doc/BRIEF.md
# JTAG Readout Security Controller

This block keeps the readout-security state of an on-chip flash as the JTAG configuration path sees it. After reset the part is treated as secured. A one-time power-up load then copies the non-volatile security bit into a local stand-in register and into the effective secured flag. The effective flag decides whether flash read, program and sector-erase commands from the configuration path are granted or refused.

A configuration session is opened with an enter pulse and closed with an exit pulse. Inside a session, a set-security command writes the stored bit high, and a full-chip-erase command clears it. A full-chip erase is the only command that clears the stored bit, and it is accepted even when the part is secured. Neither command changes the effective flag at once. Each one records a pending value, and the last one issued in the session wins. The effective flag takes the pending value when the session exits. The effective flag is mirrored into a status bit of the instruction-register capture word and into a one-bit default data register.

Top module: `rdsec_ctrl`

## Requirements
- R1: Reset (synchronous, active high) leaves `secured_o`=1, `isc_active_o`=0, `cmd_grant_o`=0 and `cmd_deny_o`=0. While no power-up load has been taken, `secured_o` stays 1.
- R2: The first `pwr_load_i` pulse after reset copies `boot_sec_i` into both `stored_sec_o` and `secured_o` on the next clock edge. Later load pulses have no effect until the next reset.
- R3: `isc_enter_i` sets `isc_active_o` and `isc_exit_i` clears it, each one cycle later. Before the power-up load, `isc_enter_i` is ignored.
- R4: Commands are coded as 0 none, 1 read, 2 program, 3 sector erase, 4 set security, 5 full-chip erase, and 6 to 7 undefined. Inside a session while `secured_o`=1, codes 1 to 3 produce `cmd_deny_o`=1 and `cmd_grant_o`=0 one cycle after `cmd_valid_i`.
- R5: Inside a session while `secured_o`=0, codes 1 to 3 produce `cmd_grant_o`=1 one cycle later. Codes 6 and 7 are always denied, and code 0 produces neither grant nor deny.
- R6: Code 5 inside a session is granted whatever the security state. It clears `stored_sec_o` one cycle later. `secured_o` keeps its value until the session exits, and then becomes 0.
- R7: Code 4 inside a session is granted and sets `stored_sec_o` one cycle later. `secured_o` keeps its value until the session exits, and then becomes 1.
- R8: When both code 4 and code 5 are issued in one session, `secured_o` after exit equals the value written by the last of them.
- R9: Any command other than code 0 that arrives outside a session, or before the power-up load, is denied and changes neither `stored_sec_o` nor `secured_o`.
- R10: `dr_status_o` and bit `SEC_POS` of `ir_capture_o` equal `secured_o`. `ir_capture_o[1:0]` is 2'b01, and all other bits are 0.
- R11: A session that exits with no code 4 or 5 granted leaves `secured_o` unchanged.
- R12: Only a granted code 5 clears `stored_sec_o`. No other command or session event lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_load_i | input | 1 | Power-up load pulse |
| boot_sec_i | input | 1 | Non-volatile security value presented at power-up |
| isc_enter_i | input | 1 | Enter configuration session pulse |
| isc_exit_i | input | 1 | Exit configuration session pulse |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (see R4) |
| cmd_grant_o | output | 1 | Command accepted, one cycle after the strobe |
| cmd_deny_o | output | 1 | Command refused, one cycle after the strobe |
| secured_o | output | 1 | Effective secured flag |
| stored_sec_o | output | 1 | Stand-in for the non-volatile security bit |
| isc_active_o | output | 1 | Configuration session open |
| ir_capture_o | output | IR_W | Instruction-register capture word with security status |
| dr_status_o | output | 1 | Default data register security status |

## Verification
Every result is registered and is due exactly one clock edge after the input that causes it. This covers the grant or deny after a command strobe, the stored bit after a granted set or erase, the session flag after enter or exit, and the effective flag after a load or an exit. The bench drives each stimulus at a falling edge, holds it across one rising edge, and compares at the next falling edge, so each check falls in the first cycle where the new value must appear. The effective flag is also compared right after each in-session command, which shows that it has not yet moved. Once the session exits, it is compared again against the pending value the bench model predicts.

// File: rtl/rdsec_pkg.sv
package rdsec_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE       = 3'd0,
    OP_READ       = 3'd1,
    OP_PROG       = 3'd2,
    OP_SECT_ERASE = 3'd3,
    OP_SET_SEC    = 3'd4,
    OP_CHIP_ERASE = 3'd5
  } sec_op_e;

  function automatic logic op_is_flash_access(input logic [OP_W-1:0] op);
    return (op == OP_READ) || (op == OP_PROG) || (op == OP_SECT_ERASE);
  endfunction

  function automatic logic op_is_sec_change(input logic [OP_W-1:0] op);
    return (op == OP_SET_SEC) || (op == OP_CHIP_ERASE);
  endfunction
endpackage

// File: rtl/rdsec_nv_store.sv
module rdsec_nv_store (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic boot_i,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_o
);
  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst)         bit_q <= 1'b1;
    else if (load_i) bit_q <= boot_i;
    else if (clr_i)  bit_q <= 1'b0;
    else if (set_i)  bit_q <= 1'b1;
  end

  assign bit_o = bit_q;

  // R12: the stored bit only drops through a chip erase or the power-up load
  p_nv_fall_src_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(bit_q) |-> $past(clr_i || load_i));

  p_set_clr_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(set_i && clr_i));
endmodule

// File: rtl/rdsec_cmd_gate.sv
module rdsec_cmd_gate
  import rdsec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            ready_i,
  input  logic            secured_i,
  output logic            set_sec_o,
  output logic            chip_erase_o,
  output logic            grant_o,
  output logic            deny_o
);
  logic accept;
  logic grant_q, deny_q;

  always_comb begin
    accept = 1'b0;
    if (valid_i && ready_i) begin
      if (op_is_sec_change(op_i))         accept = 1'b1;
      else if (op_is_flash_access(op_i))  accept = !secured_i;
    end
  end

  assign set_sec_o    = accept && (op_i == OP_SET_SEC);
  assign chip_erase_o = accept && (op_i == OP_CHIP_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= accept;
      deny_q  <= valid_i && (op_i != OP_NONE) && !accept;
    end
  end

  assign grant_o = grant_q;
  assign deny_o  = deny_q;

  p_grant_deny_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(grant_q && deny_q));

  // R4: flash access is granted only when the part was not secured
  p_secured_refuses_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_q && $past(op_is_flash_access(op_i))) |-> !$past(secured_i));

  // R9: nothing is granted outside a session
  p_grant_needs_session_r9: assert property (@(posedge clk) disable iff (rst)
    grant_q |-> $past(ready_i));
endmodule

// File: rtl/rdsec_session.sv
module rdsec_session (
  input  logic clk,
  input  logic rst,
  input  logic pwr_load_i,
  input  logic boot_i,
  input  logic enter_i,
  input  logic exit_i,
  input  logic set_i,
  input  logic clr_i,
  output logic loaded_o,
  output logic active_o,
  output logic secured_o
);
  logic loaded_q, active_q, eff_q, pend_v_q, pend_q;
  logic pend_v_n, pend_n, closing;

  always_comb begin
    pend_v_n = pend_v_q || set_i || clr_i;
    pend_n   = pend_q;
    if (set_i)      pend_n = 1'b1;
    else if (clr_i) pend_n = 1'b0;
  end

  assign closing = exit_i && active_q && !(enter_i && !active_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q <= 1'b0;
      active_q <= 1'b0;
      eff_q    <= 1'b1;
      pend_v_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (pwr_load_i && !loaded_q) begin
        loaded_q <= 1'b1;
        eff_q    <= boot_i;
      end
      if (loaded_q) begin
        if (enter_i && !active_q) active_q <= 1'b1;
        else if (closing)         active_q <= 1'b0;
      end
      if (closing) begin
        if (pend_v_n) eff_q <= pend_n;
        pend_v_q <= 1'b0;
      end else begin
        pend_v_q <= pend_v_n;
        pend_q   <= pend_n;
      end
    end
  end

  assign loaded_o  = loaded_q;
  assign active_o  = active_q;
  assign secured_o = eff_q;

  p_secure_until_load_r1: assert property (@(posedge clk) disable iff (rst)
    !loaded_q |-> eff_q);

  // R6/R7: once loaded, the effective flag moves only at a session exit
  p_eff_moves_on_exit_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(loaded_q) && (eff_q != $past(eff_q))) |-> $past(exit_i && active_q));

  p_no_session_before_load_r3: assert property (@(posedge clk) disable iff (rst)
    !loaded_q |-> !active_q);
endmodule

// File: rtl/rdsec_ctrl.sv
module rdsec_ctrl
  import rdsec_pkg::*;
#(
  parameter int IR_W    = 4,
  parameter int SEC_POS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_load_i,
  input  logic            boot_sec_i,
  input  logic            isc_enter_i,
  input  logic            isc_exit_i,
  input  logic            cmd_valid_i,
  input  logic [OP_W-1:0] cmd_op_i,
  output logic            cmd_grant_o,
  output logic            cmd_deny_o,
  output logic            secured_o,
  output logic            stored_sec_o,
  output logic            isc_active_o,
  output logic [IR_W-1:0] ir_capture_o,
  output logic            dr_status_o
);
  localparam int FIXED_BITS = 2;

  logic loaded, active, eff, set_sec, chip_erase, nv_load;

  assign nv_load = pwr_load_i && !loaded;

  rdsec_session u_session (
    .clk       (clk),
    .rst       (rst),
    .pwr_load_i(pwr_load_i),
    .boot_i    (boot_sec_i),
    .enter_i   (isc_enter_i),
    .exit_i    (isc_exit_i),
    .set_i     (set_sec),
    .clr_i     (chip_erase),
    .loaded_o  (loaded),
    .active_o  (active),
    .secured_o (eff)
  );

  rdsec_cmd_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (cmd_valid_i),
    .op_i        (cmd_op_i),
    .ready_i     (loaded && active),
    .secured_i   (eff),
    .set_sec_o   (set_sec),
    .chip_erase_o(chip_erase),
    .grant_o     (cmd_grant_o),
    .deny_o      (cmd_deny_o)
  );

  rdsec_nv_store u_nv (
    .clk   (clk),
    .rst   (rst),
    .load_i(nv_load),
    .boot_i(boot_sec_i),
    .set_i (set_sec),
    .clr_i (chip_erase),
    .bit_o (stored_sec_o)
  );

  for (genvar i = 0; i < IR_W; i++) begin : g_ir
    if (i == 0) begin : g_one
      assign ir_capture_o[i] = 1'b1;
    end else if (i < FIXED_BITS) begin : g_zero_fixed
      assign ir_capture_o[i] = 1'b0;
    end else if (i == SEC_POS) begin : g_sec
      assign ir_capture_o[i] = eff;
    end else begin : g_pad
      assign ir_capture_o[i] = 1'b0;
    end
  end

  assign secured_o    = eff;
  assign dr_status_o  = eff;
  assign isc_active_o = active;

  // R10: both status views follow the effective flag
  p_status_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    (dr_status_o == secured_o) && (ir_capture_o[SEC_POS] == secured_o));
endmodule

// File: tb/test_rdsec_ctrl.sv
module test_rdsec_ctrl;
  localparam int PERIOD  = 10;
  localparam int IR_W    = 4;
  localparam int SEC_POS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_load_i = 1'b0, boot_sec_i = 1'b0;
  logic isc_enter_i = 1'b0, isc_exit_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = 3'd0;
  logic cmd_grant_o, cmd_deny_o, secured_o, stored_sec_o, isc_active_o, dr_status_o;
  logic [IR_W-1:0] ir_capture_o;

  int compared = 0;
  int mismatched = 0;
  logic m_eff, m_nv, m_pv, m_p;

  always #(PERIOD/2) clk = ~clk;

  rdsec_ctrl #(.IR_W(IR_W), .SEC_POS(SEC_POS)) i_rdsec_ctrl (
    .clk(clk), .rst(rst), .pwr_load_i(pwr_load_i), .boot_sec_i(boot_sec_i),
    .isc_enter_i(isc_enter_i), .isc_exit_i(isc_exit_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_grant_o(cmd_grant_o), .cmd_deny_o(cmd_deny_o), .secured_o(secured_o),
    .stored_sec_o(stored_sec_o), .isc_active_o(isc_active_o),
    .ir_capture_o(ir_capture_o), .dr_status_o(dr_status_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_status(input string tag);
    chk({tag, " status R10 ir"}, int'(ir_capture_o), (int'(m_eff) << SEC_POS) | 1);
    chk({tag, " status R10 dr"}, int'(dr_status_o), int'(m_eff));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_eff = 1'b1; m_pv = 1'b0; m_p = 1'b0;
  endtask

  task automatic pulse_load(input logic b);
    boot_sec_i = b; pwr_load_i = 1'b1;
    @(negedge clk);
    pwr_load_i = 1'b0;
  endtask

  task automatic pulse_enter();
    isc_enter_i = 1'b1;
    @(negedge clk);
    isc_enter_i = 1'b0;
  endtask

  task automatic pulse_exit();
    isc_exit_i = 1'b1;
    @(negedge clk);
    isc_exit_i = 1'b0;
    if (m_pv) m_eff = m_p;
    m_pv = 1'b0;
  endtask

  // in-session command with model update
  task automatic cmd_in(input int op);
    logic g, d;
    cmd_valid_i = 1'b1; cmd_op_i = op[2:0];
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 3'd0;
    if (op >= 1 && op <= 3) g = !m_eff;
    else g = (op == 4 || op == 5);
    d = (op != 0) && !g;
    if (g && op == 4) begin m_nv = 1'b1; m_pv = 1'b1; m_p = 1'b1; end
    if (g && op == 5) begin m_nv = 1'b0; m_pv = 1'b1; m_p = 1'b0; end
    chk($sformatf("R4/R5/R6/R7 grant op=%0d", op), int'(cmd_grant_o), int'(g));
    chk($sformatf("R4/R5 deny op=%0d", op), int'(cmd_deny_o), int'(d));
    chk($sformatf("R12 R6 R7 stored op=%0d", op), int'(stored_sec_o), int'(m_nv));
    chk($sformatf("R6 R7 eff held op=%0d", op), int'(secured_o), int'(m_eff));
  endtask

  // command outside a session: refused, no state change
  task automatic cmd_out(input int op);
    cmd_valid_i = 1'b1; cmd_op_i = op[2:0];
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 3'd0;
    chk($sformatf("R9 grant op=%0d", op), int'(cmd_grant_o), 0);
    chk($sformatf("R9 deny op=%0d", op), int'(cmd_deny_o), int'(op != 0));
    chk($sformatf("R9 stored op=%0d", op), int'(stored_sec_o), int'(m_nv));
    chk($sformatf("R9 eff op=%0d", op), int'(secured_o), int'(m_eff));
  endtask

  initial begin
    #(PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_nv = 1'b1;
    do_reset();
    chk("R1 secured", int'(secured_o), 1);
    chk("R1 isc_active", int'(isc_active_o), 0);
    chk("R1 grant", int'(cmd_grant_o), 0);
    chk("R1 deny", int'(cmd_deny_o), 0);
    chk_status("R1");
    pulse_enter();
    chk("R3 enter before load", int'(isc_active_o), 0);
    cmd_out(1);
    cmd_out(5);
    chk("R1 still secured", int'(secured_o), 1);

    for (int b = 0; b < 2; b++) begin
      do_reset();
      pulse_load(b[0]);
      m_eff = b[0]; m_nv = b[0];
      chk("R2 eff load", int'(secured_o), b);
      chk("R2 stored load", int'(stored_sec_o), b);
      chk_status("R2");
      pulse_load(!b[0]);
      chk("R2 second load eff", int'(secured_o), b);
      chk("R2 second load stored", int'(stored_sec_o), b);

      for (int op = 0; op < 8; op++) cmd_out(op);

      pulse_enter();
      chk("R3 enter", int'(isc_active_o), 1);
      for (int op = 0; op < 8; op++) cmd_in(op);
      pulse_exit();
      chk("R3 exit", int'(isc_active_o), 0);
      chk("R6 eff after exit", int'(secured_o), int'(m_eff));
      chk_status("R6");

      pulse_enter();
      cmd_in(4);
      pulse_exit();
      chk("R7 eff after exit", int'(secured_o), 1);
      chk_status("R7");
      pulse_enter();
      for (int op = 1; op < 4; op++) cmd_in(op);
      pulse_exit();
      chk("R11 eff unchanged", int'(secured_o), 1);
      chk("R12 stored kept", int'(stored_sec_o), 1);

      for (int s = 0; s < 4; s++) begin
        int a = s[0] ? 5 : 4;
        int c = s[1] ? 5 : 4;
        pulse_enter();
        cmd_in(a);
        cmd_in(c);
        cmd_in(1);
        pulse_exit();
        chk($sformatf("R8 last wins a=%0d c=%0d", a, c), int'(secured_o), int'(c == 4));
        chk_status("R8");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule